// File: doc/BRIEF.md
# Branch Hazard Stall Controller

This block sits next to a fetch and dispatch stage and inspects one decoded branch descriptor per cycle. From the branch kind, the link-update bit, the static hint bit and the flags for pending condition or target producers, it decides whether the branch can enter the pipe. If the branch conflicts with an older branch that is still unresolved, the block holds fetch. A branch that is held stays presented, and it is taken in on the first cycle with no stall.

When a conditional branch must wait for its condition operand, the block does not stall. It issues a predicted direction from the hint bit instead, and it keeps that single prediction outstanding until a resolve input arrives. On the cycle after the resolve, it flags a misprediction if the actual direction differs from the stored one. Only one prediction may be outstanding at a time. Computing target addresses and evaluating condition codes are done elsewhere.

Top module: `branch_stall_ctrl`

## Requirements
- R1: The branch kind is carried by `in_kind`: 0 = conditional on count, 1 = conditional on condition register, 2 = jump through count register, 3 = jump through link register, 4 = unconditional immediate. A kind-0 branch that arrives while an earlier accepted kind-0 branch has not yet completed (`ctr_done`) raises `fetch_stall`.
- R2: A kind-2 branch that arrives while an earlier kind-0 branch has not yet completed raises `fetch_stall`.
- R3: A branch with `in_link`=1 of kind 0 to 3 that arrives while an earlier accepted link-updating branch has not yet completed (`lnk_done`) raises `fetch_stall`.
- R4: A kind-4 branch never stalls, whatever its link bit and whatever older branches are pending.
- R5: Only one prediction may be outstanding. While one is unresolved, any kind-1 branch, and any branch that would need a prediction, raises `fetch_stall`.
- R6: For a kind-0 branch with `in_ctr_decides`=1, the count test alone settles the outcome and `in_cr_wait` is ignored: no prediction is issued, and no stall arises from an outstanding prediction.
- R7: A kind-2 or kind-3 branch with `in_tgt_wait`=1 raises `fetch_stall` for as long as that flag stays high.
- R8: An accepted branch with `in_cr_wait`=1 that is either kind 1, or kind 0 with `in_ctr_decides`=0, drives `pred_vld`=1 in the same cycle. In that cycle `pred_taken` equals `in_hint` (1 = taken).
- R9: While a prediction is outstanding, `res_vld` ends it. `mispredict` is high for exactly the following cycle if `res_taken` differs from the stored hint, and stays low if they match. A resolve with no outstanding prediction has no effect.
- R10: A stall caused by an older branch is dropped on the cycle after that branch's `ctr_done`, `lnk_done` or `res_vld`.
- R11: Synchronous active-low reset clears all pending state. After reset, no stall, prediction or mispredict is present until new branches are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | A branch descriptor is presented |
| in_kind | input | 3 | Branch kind code (see R1) |
| in_link | input | 1 | Branch updates the link register |
| in_hint | input | 1 | Static hint, 1 = taken |
| in_cr_wait | input | 1 | Condition operand not yet ready |
| in_tgt_wait | input | 1 | Target register still being produced |
| in_ctr_decides | input | 1 | Count test alone decides the outcome |
| ctr_done | input | 1 | Oldest count-conditional branch completed |
| lnk_done | input | 1 | Oldest link-updating branch completed |
| res_vld | input | 1 | Predicted branch resolved |
| res_taken | input | 1 | Actual direction of resolved branch |
| fetch_stall | output | 1 | Hold fetch; descriptor not accepted |
| pred_vld | output | 1 | Prediction issued for the accepted branch |
| pred_taken | output | 1 | Predicted direction |
| mispredict | output | 1 | One-cycle misprediction pulse |

## Verification
`fetch_stall`, `pred_vld` and `pred_taken` are combinational on the presented descriptor and the registered pending state, so they are due in the same cycle the descriptor is driven. `mispredict`, and the drop of a stall after a done or resolve input, are due exactly one clock later. The bench drives inputs at the falling edge and compares all outputs one nanosecond later. It advances its reference model only at the rising edge, so each result is checked in the cycle it belongs to.

// File: rtl/hz_pkg.sv
// Shared types for the branch hazard stall controller.
// Assumes branch kinds are coded in KIND_W bits as listed below.
package hz_pkg;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_COND_CNT  = 3'd0,
        K_COND_CR   = 3'd1,
        K_JMP_CTREG = 3'd2,
        K_JMP_LRREG = 3'd3,
        K_UNCOND    = 3'd4
    } br_kind_e;
endpackage

// File: rtl/hz_flag.sv
// One pending-branch flag: set when a branch of a tracked class is accepted,
// cleared by that branch's completion. Set wins over clear in the same cycle.
// Assumes at most one branch per class is outstanding (upstream is stalled otherwise).
module hz_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    // Track whether an older branch of this class is still in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_o <= 1'b0;
        else if (set_i)
            pend_o <= 1'b1;
        else if (clr_i)
            pend_o <= 1'b0;
    end
endmodule

// File: rtl/hz_conflict.sv
// Pairwise hazard rules between a new branch descriptor and older pending state.
// Purely combinational. Also reports whether the new branch needs a prediction.
// Assumes the kind code of hz_pkg; unknown codes behave like an unconditional branch.
module hz_conflict
    import hz_pkg::*;
(
    input  logic              vld_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic              link_i,
    input  logic              cr_wait_i,
    input  logic              tgt_wait_i,
    input  logic              ctr_decides_i,
    input  logic              ctr_pend_i,
    input  logic              lnk_pend_i,
    input  logic              pred_pend_i,
    output logic              need_pred_o,
    output logic              stall_o
);
    br_kind_e kind;
    logic     s_ctr, s_lnk, s_spec, s_tgt;

    // Decode the kind and evaluate each hazard rule independently.
    always_comb begin
        kind        = br_kind_e'(kind_i);
        need_pred_o = cr_wait_i &&
                      ((kind == K_COND_CR) ||
                       ((kind == K_COND_CNT) && !ctr_decides_i));
        s_ctr  = ctr_pend_i && ((kind == K_COND_CNT) || (kind == K_JMP_CTREG));
        s_lnk  = lnk_pend_i && link_i &&
                 ((kind == K_COND_CNT) || (kind == K_COND_CR) ||
                  (kind == K_JMP_CTREG) || (kind == K_JMP_LRREG));
        s_spec = pred_pend_i && ((kind == K_COND_CR) || need_pred_o);
        s_tgt  = tgt_wait_i && ((kind == K_JMP_CTREG) || (kind == K_JMP_LRREG));
        stall_o = vld_i && (s_ctr || s_lnk || s_spec || s_tgt);
    end

    // Immediate unconditional branches are never held (R4).
    always_comb begin
        if (vld_i && (kind_i == 3'(K_UNCOND)))
            assert_imm_free_R4: assert (!stall_o);
    end
endmodule

// File: rtl/hz_spec_slot.sv
// Single-level speculation slot: stores the hint of the one outstanding prediction,
// clears it on resolve and raises a registered one-cycle mispredict pulse.
// Assumes issue_i is never high while a prediction is outstanding.
module hz_spec_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    input  logic hint_i,
    input  logic res_vld_i,
    input  logic res_taken_i,
    output logic pend_o,
    output logic mis_o
);
    logic dir_q;

    // Hold prediction state and compare against the resolved direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            dir_q  <= 1'b0;
            mis_o  <= 1'b0;
        end else begin
            mis_o <= res_vld_i && pend_o && (res_taken_i != dir_q);
            if (issue_i) begin
                pend_o <= 1'b1;
                dir_q  <= hint_i;
            end else if (res_vld_i) begin
                pend_o <= 1'b0;
            end
        end
    end

    assert_single_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> !pend_o);

    assert_mis_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mis_o |-> $past(res_vld_i && pend_o));
endmodule

// File: rtl/branch_stall_ctrl.sv
// Branch hazard stall controller: holds fetch on pairwise branch conflicts,
// issues one level of static prediction and reports mispredictions.
// Assumes a stalled descriptor stays presented until accepted.
module branch_stall_ctrl
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [KIND_W-1:0] in_kind,
    input  logic              in_link,
    input  logic              in_hint,
    input  logic              in_cr_wait,
    input  logic              in_tgt_wait,
    input  logic              in_ctr_decides,
    input  logic              ctr_done,
    input  logic              lnk_done,
    input  logic              res_vld,
    input  logic              res_taken,
    output logic              fetch_stall,
    output logic              pred_vld,
    output logic              pred_taken,
    output logic              mispredict
);
    logic ctr_pend, lnk_pend, pred_pend;
    logic need_pred, accept, issue;

    hz_conflict i_rules (
        .vld_i        (in_vld),
        .kind_i       (in_kind),
        .link_i       (in_link),
        .cr_wait_i    (in_cr_wait),
        .tgt_wait_i   (in_tgt_wait),
        .ctr_decides_i(in_ctr_decides),
        .ctr_pend_i   (ctr_pend),
        .lnk_pend_i   (lnk_pend),
        .pred_pend_i  (pred_pend),
        .need_pred_o  (need_pred),
        .stall_o      (fetch_stall)
    );

    // Acceptance and prediction issue for the presented descriptor.
    always_comb begin
        accept     = in_vld && !fetch_stall;
        issue      = accept && need_pred;
        pred_vld   = issue;
        pred_taken = issue && in_hint;
    end

    hz_flag i_ctr_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (accept && (in_kind == 3'(K_COND_CNT))),
        .clr_i (ctr_done),
        .pend_o(ctr_pend)
    );

    hz_flag i_lnk_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (accept && in_link),
        .clr_i (lnk_done),
        .pend_o(lnk_pend)
    );

    hz_spec_slot i_spec (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_i    (issue),
        .hint_i     (in_hint),
        .res_vld_i  (res_vld),
        .res_taken_i(res_taken),
        .pend_o     (pred_pend),
        .mis_o      (mispredict)
    );

    assert_ctr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && ctr_pend && !ctr_done && in_kind == 3'(K_COND_CNT))
        |=> (!in_vld || in_kind != 3'(K_COND_CNT) || fetch_stall));

    assert_lnk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && lnk_pend && in_link && in_kind == 3'(K_JMP_LRREG)) |-> !pred_vld && fetch_stall);

    assert_tgt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_tgt_wait && in_kind == 3'(K_JMP_CTREG)) |-> fetch_stall);

    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> !mispredict);
endmodule

// File: tb/test_branch_stall_ctrl.sv
module test_branch_stall_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 0, in_link = 0, in_hint = 0, in_cr_wait = 0, in_tgt_wait = 0;
    logic in_ctr_decides = 0, ctr_done = 0, lnk_done = 0, res_vld = 0, res_taken = 0;
    logic [2:0] in_kind = 3'd0;
    logic fetch_stall, pred_vld, pred_taken, mispredict;

    int checks = 0;
    int errors = 0;
    bit m_ctr = 0, m_lnk = 0, m_pred = 0, m_dir = 0, m_mis = 0;
    bit first = 1;

    always #5 clk = ~clk;

    branch_stall_ctrl i_branch_stall_ctrl (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_kind(in_kind),
        .in_link(in_link), .in_hint(in_hint), .in_cr_wait(in_cr_wait),
        .in_tgt_wait(in_tgt_wait), .in_ctr_decides(in_ctr_decides),
        .ctr_done(ctr_done), .lnk_done(lnk_done), .res_vld(res_vld),
        .res_taken(res_taken), .fetch_stall(fetch_stall), .pred_vld(pred_vld),
        .pred_taken(pred_taken), .mispredict(mispredict)
    );

    function automatic bit want_pred();
        return in_cr_wait && (in_kind == 3'd1 || (in_kind == 3'd0 && !in_ctr_decides));
    endfunction

    // Expected stall and which requirement explains it.
    function automatic string stall_why(output bit s);
        s = 0;
        if (!in_vld) return "R10";
        if (in_kind == 3'd4) return "R4";
        if (m_ctr && (in_kind == 3'd0 || in_kind == 3'd2)) begin s = 1; return (in_kind == 3'd0) ? "R1" : "R2"; end
        if (m_lnk && in_link) begin s = 1; return "R3"; end
        if (m_pred && (in_kind == 3'd1 || want_pred())) begin s = 1; return "R5"; end
        if (in_tgt_wait && (in_kind == 3'd2 || in_kind == 3'd3)) begin s = 1; return "R7"; end
        if (in_kind == 3'd0 && in_ctr_decides && in_cr_wait) return "R6";
        return "R10";
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, compare 1ns later, advance model at the rising edge.
    task automatic cyc(bit v, int k, bit l, bit h, bit cw, bit tw, bit dec,
                       bit cd, bit ld, bit rv, bit rt);
        bit s, acc, iss;
        string why;
        @(negedge clk);
        in_vld = v; in_kind = 3'(k); in_link = l; in_hint = h; in_cr_wait = cw;
        in_tgt_wait = tw; in_ctr_decides = dec; ctr_done = cd; lnk_done = ld;
        res_vld = rv; res_taken = rt;
        #1;
        why = stall_why(s);
        if (first) why = "R11";
        acc = v && !s;
        iss = acc && want_pred();
        check(why, "fetch_stall", fetch_stall, s);
        check(first ? "R11" : (in_kind == 3'd0 && in_ctr_decides ? "R6" : "R8"), "pred_vld", pred_vld, iss);
        check("R8", "pred_taken", pred_taken, iss && h);
        check(first ? "R11" : "R9", "mispredict", mispredict, m_mis);
        first = 0;
        @(posedge clk);
        m_mis = rv && m_pred && (rt != m_dir);
        if (iss) begin m_pred = 1; m_dir = h; end else if (rv) m_pred = 0;
        if (acc && k == 0) m_ctr = 1; else if (cd) m_ctr = 0;
        if (acc && l) m_lnk = 1; else if (ld) m_lnk = 0;
    endtask

    task automatic idle(); cyc(0,0,0,0,0,0,0,0,0,0,0); endtask

    initial begin
        fork
            begin : watchdog
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        idle();                                   // R11 reset state
        // R1, R10: count-conditional after pending count-conditional
        cyc(1,0,0,0,0,0,0,0,0,0,0);
        cyc(1,0,0,0,0,0,0,0,0,0,0);
        cyc(1,0,0,0,0,0,0,1,0,0,0);               // done this cycle, still stalled
        cyc(1,0,0,0,0,0,0,0,0,0,0);               // R10 accepted next cycle
        // R2: jump through count register after pending count branch
        cyc(1,2,0,0,0,0,0,0,0,0,0);
        cyc(1,2,0,0,0,0,0,1,0,0,0);
        cyc(1,2,0,0,0,0,0,0,0,0,0);
        // R3, R4: link after link, immediate exempt
        cyc(1,1,1,0,0,0,0,0,0,0,0);
        cyc(1,3,1,0,0,0,0,0,0,0,0);
        cyc(1,4,1,0,0,0,0,0,0,0,0);
        cyc(1,3,1,0,0,0,0,0,1,0,0);
        cyc(1,3,1,0,0,0,0,0,0,0,0);
        idle(); cyc(0,0,0,0,0,0,0,0,1,0,0);
        // R8, R5, R9: predict taken, second CR branch stalls, resolve not-taken
        cyc(1,1,0,1,1,0,0,0,0,0,0);
        cyc(1,1,0,0,0,0,0,0,0,0,0);
        cyc(1,1,0,0,0,0,0,0,0,1,0);
        cyc(1,1,0,0,0,0,0,0,0,0,0);               // mispredict pulse, R10 accept
        idle();
        // R9: correct prediction gives no pulse
        cyc(1,1,0,0,1,0,0,0,0,0,0);
        cyc(0,0,0,0,0,0,0,0,0,1,0);
        idle();
        // R9: resolve with nothing outstanding is ignored
        cyc(0,0,0,0,0,0,0,0,0,1,1);
        idle();
        // R6: count decides with pending prediction present
        cyc(1,1,0,1,1,0,0,0,0,0,0);
        cyc(1,0,0,1,1,0,1,0,0,0,0);
        cyc(0,0,0,0,0,0,0,1,0,1,1);
        idle();
        // R7: target hold
        cyc(1,3,0,0,0,1,0,0,0,0,0);
        cyc(1,2,0,0,0,1,0,0,0,0,0);
        cyc(1,2,0,0,0,0,0,0,0,0,0);
        // random mix
        for (int i = 0; i < 400; i++)
            cyc($urandom_range(1), $urandom_range(4), $urandom_range(1), $urandom_range(1),
                $urandom_range(1), ($urandom_range(3) == 0), $urandom_range(1),
                ($urandom_range(2) == 0), ($urandom_range(2) == 0),
                ($urandom_range(2) == 0), $urandom_range(1));
        // R11: reset in the middle clears everything
        cyc(1,1,1,1,1,0,0,0,0,0,0);
        @(negedge clk); rst_n = 0; in_vld = 0;
        @(posedge clk);
        m_ctr = 0; m_lnk = 0; m_pred = 0; m_mis = 0;
        @(negedge clk); rst_n = 1;
        first = 1;
        idle();
        cyc(1,1,1,0,1,0,0,0,0,0,0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule